// File: doc/BRIEF.md
# UART with Sticky Status Flags

This block is a byte-wide serial transmitter and receiver with a 16-entry FIFO on each side and a small register interface. Software or a DMA engine loads bytes into the transmit FIFO, and the transmitter sends them out. The receiver samples the incoming line, checks the stop bit and, if enabled, the parity bit. It then stores each character in the receive FIFO together with its own framing and parity tags.

Three sticky flags sit in the status register: a receive-error flag, a transmit-end flag and a receive-overrun flag. A flag can only be cleared through a handshake. Software must first read the flag as 1 and then write 0 to that bit. A bad character does not stop the receiver: it is stored with its tags, and the next characters are received normally. The transmit-end flag is set when the transmitter runs dry after a stop bit, and it is held set while the transmitter is disabled. It is cleared either by the handshake or by a DMA write into the transmit FIFO.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status register (address 1) reads 0x40, the control register (address 2) reads 0x00, and the transmit line is high.
- R2: A transmitted frame is a start bit of 0, then 8 data bits with the LSB first, then a parity bit if control bit 2 is set, then a stop bit of 1. Each bit lasts CLKS_PER_BIT clocks. The parity bit makes the count of ones even, or odd when control bit 3 is set.
- R3: With control bit 1 (receive enable) set, each received character is placed in the receive FIFO. Status bit 2 reads 1 while the FIFO holds data. A read of address 0 returns the head byte and removes it.
- R4: A stop bit sampled as 0 sets the receive-error flag (status bit 7) and tags that entry with a framing tag, visible in status bit 4 while the entry is at the head. The character is still stored, and the next character is received normally.
- R5: With parity enabled, a character whose data bits plus parity bit do not match the configured even or odd parity sets status bit 7 and tags the entry with a parity tag, visible in status bit 3.
- R6: A flag clears only when status is written with 0 in that bit after a status read that returned the bit as 1. A write of 0 with no such read leaves the flag unchanged. A write of 1 never sets a flag. Any status write cancels a pending read.
- R7: Clearing the receive enable leaves the receive-error flag unchanged.
- R8: The transmit-end flag (status bit 6) sets when the stop bit of a character completes and the transmit FIFO is empty. It is held at 1 while control bit 0 (transmit enable) is 0, and it is cleared by the R6 handshake.
- R9: A DMA write pushes its byte into the transmit FIFO and clears the transmit-end flag. The byte is transmitted like a byte written by software.
- R10: A character that arrives while the receive FIFO holds 16 entries is dropped and sets the overrun flag (status bit 5). The 16 entries already stored are kept in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| dma_wr | input | 1 | DMA write strobe into the transmit FIFO |
| dma_data | input | 8 | DMA write byte |
| rxd_i | input | 1 | Serial receive line, idles high |
| txd_o | output | 1 | Serial transmit line, idles high |

## Verification
On every cycle, the assertions check the flag rules. A stored character with a framing or parity tag is followed by the error flag. A flag falls only after a write that completes the handshake, or for transmit-end, after a DMA write. The transmit-end flag follows a disabled transmitter. A push into a full FIFO never moves its write pointer. Only the bench scenarios can show the serial behaviour: frame bit order and timing, the parity bit values, the receiver carrying on after a bad stop bit, and the order of the entries kept when an overrun occurs.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} bit_state_e;
    localparam int NFLAGS    = 3;
    localparam int FLAG_OVR  = 0;   // status bit 5
    localparam int FLAG_TEND = 1;   // status bit 6
    localparam int FLAG_ERR  = 2;   // status bit 7
    localparam int FLAG_LSB  = 5;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
endpackage

// File: rtl/uart_flag_fifo.sv
module uart_flag_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];

    assign empty_o = (q.wp == q.rp);
    assign full_o  = (q.wp[AW] != q.rp[AW]) && (q.wp[AW-1:0] == q.rp[AW-1:0]);
    assign head_o  = mem[q.rp[AW-1:0]];

    always_comb begin
        d = q;
        if (push_i && !full_o) d.wp = q.wp + 1'b1;
        if (pop_i && !empty_o) d.rp = q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i && !full_o) mem[q.wp[AW-1:0]] <= data_i;
    end

    // R10: a push into a full FIFO is dropped
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i) |=> (q.wp == $past(q.wp)));
endmodule

// File: rtl/uart_flag_rx.sv
module uart_flag_rx
    import uart_flag_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       rxd_i,
    output logic       push_o,
    output logic [7:0] data_o,
    output logic       fe_o,
    output logic       pe_o
);
    localparam int CW = $clog2(CLKS_PER_BIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    typedef struct packed {
        bit_state_e    st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    sh;
        logic          par;
    } rx_t;

    rx_t q, d;

    assign data_o = q.sh;
    assign fe_o   = ~rxd_i;
    assign pe_o   = par_en_i && ((^q.sh ^ q.par) != par_odd_i);

    always_comb begin
        d      = q;
        push_o = 1'b0;
        if (!en_i) begin
            d.st  = S_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    d.cnt = '0;
                    if (!rxd_i) d.st = S_START;
                end
                S_START: begin
                    if (q.cnt == HALF) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rxd_i ? S_IDLE : S_DATA;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {rxd_i, q.sh[7:1]};
                        if (q.idx == 3'd7) d.st = par_en_i ? S_PAR : S_STOP;
                        else               d.idx = q.idx + 1'b1;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_PAR: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.par = rxd_i;
                        d.st  = S_STOP;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_STOP: begin
                    if (q.cnt == LAST) begin
                        push_o = 1'b1;
                        d.cnt  = '0;
                        d.st   = S_IDLE;
                    end else d.cnt = q.cnt + 1'b1;
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/uart_flag_tx.sv
module uart_flag_tx #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       avail_i,
    input  logic [7:0] data_i,
    output logic       pop_o,
    output logic       done_o,
    output logic       txd_o
);
    localparam int CW = $clog2(CLKS_PER_BIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    typedef struct packed {
        logic          busy;
        logic [10:0]   sh;
        logic [3:0]    left;
        logic [CW-1:0] cnt;
    } tx_t;

    tx_t q, d;

    assign txd_o = q.busy ? q.sh[0] : 1'b1;

    always_comb begin
        d      = q;
        pop_o  = 1'b0;
        done_o = 1'b0;
        if (!q.busy) begin
            if (en_i && avail_i) begin
                pop_o  = 1'b1;
                d.busy = 1'b1;
                d.cnt  = '0;
                d.sh   = {1'b1, par_en_i ? (^data_i ^ par_odd_i) : 1'b1, data_i, 1'b0};
                d.left = par_en_i ? 4'd11 : 4'd10;
            end
        end else if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.sh   = {1'b1, q.sh[10:1]};
            d.left = q.left - 1'b1;
            if (q.left == 4'd1) begin
                d.busy = 1'b0;
                done_o = 1'b1;
            end
        end else d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int FIFO_DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       dma_wr,
    input  logic [7:0] dma_data,
    input  logic       rxd_i,
    output logic       txd_o
);
    localparam int RXW = 10;   // {framing tag, parity tag, byte}

    typedef struct packed {
        logic [NFLAGS-1:0] flags;
        logic [NFLAGS-1:0] armed;
        logic              tx_en;
        logic              rx_en;
        logic              par_en;
        logic              par_odd;
        logic [1:0]        sync;
    } ctl_t;

    ctl_t q, d;

    logic           rx_push, rx_fe, rx_pe, rx_full, rx_empty;
    logic [7:0]     rx_byte;
    logic [RXW-1:0] rx_head;
    logic           tx_pop, tx_done, tx_full, tx_empty, tx_push;
    logic [7:0]     tx_head, tx_byte;
    logic           stat_wr, stat_rd, data_rd;
    logic [NFLAGS-1:0] set_ev, clr_ev;

    assign stat_wr = bus_wr && (bus_addr == A_STAT);
    assign stat_rd = bus_rd && (bus_addr == A_STAT);
    assign data_rd = bus_rd && (bus_addr == A_DATA);
    assign tx_push = dma_wr || (bus_wr && (bus_addr == A_DATA));
    assign tx_byte = dma_wr ? dma_data : bus_wdata;

    uart_flag_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
        .clk(clk), .rst_n(rst_n), .en_i(q.rx_en), .par_en_i(q.par_en),
        .par_odd_i(q.par_odd), .rxd_i(q.sync[1]), .push_o(rx_push),
        .data_o(rx_byte), .fe_o(rx_fe), .pe_o(rx_pe));

    uart_flag_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .data_i({rx_fe, rx_pe, rx_byte}),
        .pop_i(data_rd), .head_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

    uart_flag_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push), .data_i(tx_byte),
        .pop_i(tx_pop), .head_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

    uart_flag_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
        .clk(clk), .rst_n(rst_n), .en_i(q.tx_en), .par_en_i(q.par_en),
        .par_odd_i(q.par_odd), .avail_i(!tx_empty), .data_i(tx_head),
        .pop_o(tx_pop), .done_o(tx_done), .txd_o(txd_o));

    always_comb begin
        set_ev            = '0;
        set_ev[FLAG_ERR]  = rx_push && (rx_fe || rx_pe);
        set_ev[FLAG_OVR]  = rx_push && rx_full;
        set_ev[FLAG_TEND] = tx_done && tx_empty;
        for (int i = 0; i < NFLAGS; i++)
            clr_ev[i] = stat_wr && !bus_wdata[FLAG_LSB+i] && q.armed[i];
        clr_ev[FLAG_TEND] = clr_ev[FLAG_TEND] || dma_wr;
    end

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd_i};
        for (int i = 0; i < NFLAGS; i++) begin
            if (set_ev[i])      d.flags[i] = 1'b1;
            else if (clr_ev[i]) d.flags[i] = 1'b0;
            if (stat_wr)                     d.armed[i] = 1'b0;
            else if (stat_rd && q.flags[i])  d.armed[i] = 1'b1;
        end
        if (!q.tx_en) d.flags[FLAG_TEND] = 1'b1;
        if (bus_wr && (bus_addr == A_CTRL)) begin
            d.tx_en   = bus_wdata[0];
            d.rx_en   = bus_wdata[1];
            d.par_en  = bus_wdata[2];
            d.par_odd = bus_wdata[3];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = rx_head[7:0];
            A_STAT:  bus_rdata = {q.flags, rx_head[9] & ~rx_empty, rx_head[8] & ~rx_empty,
                                  ~rx_empty, tx_full, 1'b0};
            A_CTRL:  bus_rdata = {4'b0, q.par_odd, q.par_en, q.rx_en, q.tx_en};
            default: bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{flags: 3'b010, sync: 2'b11, default: '0};
        else        q <= d;
    end

    // R4: a stored character with a bad stop bit raises the error flag
    p_frame_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_fe) |=> q.flags[FLAG_ERR]);
    // R5: a parity mismatch raises the error flag
    p_parity_sets_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pe) |=> q.flags[FLAG_ERR]);
    // R6: the error flag only falls after a completed handshake
    p_err_clear_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flags[FLAG_ERR]) |-> $past(stat_wr && !bus_wdata[7] && q.armed[FLAG_ERR]));
    // R8: transmit-end is held while the transmitter is disabled
    p_tend_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.tx_en |=> q.flags[FLAG_TEND]);
    // R9: transmit-end falls only by handshake or DMA write
    p_tend_clear_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flags[FLAG_TEND]) |->
        $past(dma_wr || (stat_wr && !bus_wdata[6] && q.armed[FLAG_TEND])));
    // R10: a character arriving at a full receive FIFO raises overrun
    p_overrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> q.flags[FLAG_OVR]);
endmodule

// File: tb/uart_flag_ctrl_tb_top.sv
module uart_flag_ctrl_tb_top;
    localparam int CPB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, dma_wr = 1'b0;
    logic [7:0] bus_wdata = '0, dma_data = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    uart_flag_ctrl #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_wr(dma_wr), .dma_data(dma_data),
        .rxd_i(rxd), .txd_o(txd));

    function automatic logic par_bit(input logic [7:0] b, input logic odd);
        return ^b ^ odd;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic dma(input logic [7:0] v);
        @(negedge clk); dma_data = v; dma_wr = 1'b1;
        @(negedge clk); dma_wr = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic pe, input logic odd,
                           input logic bad_par, input logic bad_stop);
        rxd = 1'b0; repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (CPB) @(negedge clk); end
        if (pe) begin rxd = par_bit(b, odd) ^ bad_par; repeat (CPB) @(negedge clk); end
        rxd = !bad_stop; repeat (CPB) @(negedge clk);
        rxd = 1'b1; repeat (2*CPB) @(negedge clk);
    endtask

    task automatic grab_tx(input logic pe, output logic [7:0] b, output logic p,
                           output logic stop, output logic start);
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (CPB/2) @(negedge clk);
        start = txd;
        for (int i = 0; i < 8; i++) begin repeat (CPB) @(negedge clk); b[i] = txd; end
        p = 1'b0;
        if (pe) begin repeat (CPB) @(negedge clk); p = txd; end
        repeat (CPB) @(negedge clk); stop = txd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, b;
        logic p, stp, sta, pe, odd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); chk("R1 status", v, 8'h40);
        rd(2'd2, v); chk("R1 control", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);

        // R3 directed receive
        wr(2'd2, 8'h02);
        send_rx(8'hA5, 0, 0, 0, 0);
        rd(2'd1, v); chk("R3 not empty", v[2], 1'b1);
        rd(2'd0, v); chk("R3 data", v, 8'hA5);
        rd(2'd1, v); chk("R3 empty after pop", v[2], 1'b0);

        // R3/R5 random clean characters, parity varied
        for (int n = 0; n < 20; n++) begin
            b = 8'($urandom); pe = 1'($urandom); odd = 1'($urandom);
            wr(2'd2, {4'b0, odd, pe, 2'b10});
            send_rx(b, pe, odd, 0, 0);
            rd(2'd1, v); chk("R5 clean tags and flag", {v[7], v[4:3]}, 3'b000);
            rd(2'd0, v); chk("R3 random data", v, b);
        end

        // R5 even parity error
        wr(2'd2, 8'h06);
        send_rx(8'h3C, 1, 0, 1, 0);
        // R6 write 0 without prior read has no effect
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R5 err flag", v[7], 1'b1); chk("R5 parity tag", v[4:3], 2'b01);
        // R6 write of 1 cancels the armed read
        wr(2'd1, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6 unarmed zero write", v[7], 1'b1);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6 handshake clears", v[7], 1'b0);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk("R6 write 1 never sets", v[7], 1'b0);
        rd(2'd0, v); chk("R5 errored char stored", v, 8'h3C);

        // R5 odd parity error
        wr(2'd2, 8'h0E);
        send_rx(8'h81, 1, 1, 1, 0);
        rd(2'd1, v); chk("R5 odd parity tag", {v[7], v[4:3]}, 3'b101);
        wr(2'd1, 8'h00);
        rd(2'd0, v); chk("R5 odd data", v, 8'h81);

        // R4 framing error then normal character
        wr(2'd2, 8'h02);
        rd(2'd1, v); chk("R4 flag clear first", v[7], 1'b0);
        send_rx(8'h5E, 0, 0, 0, 1);
        send_rx(8'h17, 0, 0, 0, 0);
        rd(2'd1, v); chk("R4 err and framing tag", {v[7], v[4:3]}, 3'b110);
        rd(2'd0, v); chk("R4 bad-stop char stored", v, 8'h5E);
        rd(2'd1, v); chk("R4 next char untagged", v[4:2], 3'b001);
        rd(2'd0, v); chk("R4 next char data", v, 8'h17);

        // R7 disabling receive keeps the error flag
        wr(2'd2, 8'h00);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R7 flag kept", v[7], 1'b1);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R7 cleared by handshake", v[7], 1'b0);

        // R10 overrun
        wr(2'd2, 8'h02);
        for (int n = 0; n < 17; n++) send_rx(8'(n*7+3), 0, 0, 0, 0);
        rd(2'd1, v); chk("R10 overrun flag", v[5], 1'b1);
        for (int n = 0; n < 16; n++) begin
            rd(2'd0, v); chk("R10 kept order", v, 8'(n*7+3));
        end
        rd(2'd1, v); chk("R10 empty after 16", v[2], 1'b0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R10 overrun cleared", v[5], 1'b0);

        // R8 transmit-end: handshake clear, set after last stop bit
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R8 tend set before use", v[6], 1'b1);
        fork
            grab_tx(0, b, p, stp, sta);
            begin
                wr(2'd0, 8'hC3);
                wr(2'd1, 8'h00);
                rd(2'd1, v); chk("R8 tend cleared by handshake", v[6], 1'b0);
            end
        join
        chk("R2 start bit", sta, 1'b0);
        chk("R2 data", b, 8'hC3);
        chk("R2 stop bit", stp, 1'b1);
        repeat (CPB) @(negedge clk);
        rd(2'd1, v); chk("R8 tend after last bit", v[6], 1'b1);

        // R2 random transmit frames
        for (int n = 0; n < 10; n++) begin
            logic [7:0] tb;
            tb = 8'($urandom); pe = 1'($urandom); odd = 1'($urandom);
            wr(2'd2, {4'b0, odd, pe, 2'b01});
            fork
                grab_tx(pe, b, p, stp, sta);
                wr(2'd0, tb);
            join
            chk("R2 random data", b, tb);
            chk("R2 random parity", p, pe ? par_bit(tb, odd) : 1'b0);
            chk("R2 random stop", stp, 1'b1);
            repeat (CPB) @(negedge clk);
        end

        // R9 DMA write clears transmit-end and is sent
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R9 tend before dma", v[6], 1'b1);
        fork
            grab_tx(0, b, p, stp, sta);
            begin
                dma(8'h6D);
                rd(2'd1, v); chk("R9 tend cleared by dma", v[6], 1'b0);
            end
        join
        chk("R9 dma data sent", b, 8'h6D);
        repeat (CPB) @(negedge clk);
        rd(2'd1, v); chk("R9 tend set again", v[6], 1'b1);

        // R8 held while transmit disabled
        rd(2'd1, v);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R8 tend cleared while idle", v[6], 1'b0);
        wr(2'd2, 8'h00);
        repeat (2) @(negedge clk);
        rd(2'd1, v); chk("R8 tend held when disabled", v[6], 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule